// File: doc/BRIEF.md
# Prioritised CPU Interrupt Delivery Unit

This block sits between the interrupt sources of a system and a processor core. It latches three kinds of request: a reset request pulse, a non-maskable request pulse, and a maskable interrupt level that arrives with a change strobe. At every instruction boundary the core signals, the block evaluates what is pending and raises at most one exception request. That request is a single-cycle pulse with a two-bit type code.

The block also owns the hardware-interrupt pending field of the core's cause register and presents it on `cause_ip_o`. A maskable level is delivered only when the core's global interrupt enable is set and the level shares at least one bit with the core's interrupt mask. A level that is masked stays pending and is tried again at each later boundary.

A level change to zero does not mean "nothing pending". It is kept as an end-of-interrupt marker. At the next evaluation that reaches the level slot, the marker clears the cause field without raising anything, and the marker is then used up.

Top module: `cpu_irq_arbiter`

## Requirements
- R1: A synchronous active-high `rst` clears all pending requests and `cause_ip_o`. After it, no boundary raises an exception until a new request arrives.
- R2: A `rst_req_i` pulse is held until the next cycle with `boundary_i` high. In that cycle `exc_valid_o` is 1 and `exc_kind_o` is 2'b01 (combined NMI/reset). The request is then cleared, so the following boundary raises nothing.
- R3: An `nmi_req_i` pulse behaves the same way. It raises `exc_kind_o` = 2'b01 once at the next boundary and is then cleared.
- R4: Only one request is serviced per boundary, in the order reset, then NMI, then the level slot. A reset and an NMI requested in the same cycle give two consecutive NMI/reset exceptions at two boundaries.
- R5: `exc_valid_o` is high only in a cycle with `boundary_i` high, for that one cycle. Requests are held for any number of cycles without a boundary. When `exc_valid_o` is 0, `exc_kind_o` is 2'b00.
- R6: At a boundary that evaluates a nonzero pending level, `cause_ip_o` takes the pending level bits from the next cycle on. `cause_ip_o` changes at no other time except R9 and R1.
- R7: A pending nonzero level is delivered as `exc_kind_o` = 2'b10 only when `ie_i` is 1 and (level AND `im_i`) is nonzero. Delivery clears the pending level; `cause_ip_o` keeps the level bits.
- R8: A level that is disabled or masked raises nothing and stays pending. It is delivered at the first later boundary where R7 holds.
- R9: A level change to zero sets an end-of-interrupt marker. The next boundary that reaches the level slot clears `cause_ip_o` to 0 without an exception and uses up the marker.
- R10: A new level change replaces whatever level or marker is still pending.
- R11: While a reset or NMI request takes a boundary, the level slot is not evaluated and `cause_ip_o` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high block reset |
| rst_req_i | input | 1 | Reset request pulse |
| nmi_req_i | input | 1 | Non-maskable request pulse |
| lvl_chg_i | input | 1 | Strobe: `lvl_i` carries a new level |
| lvl_i | input | LVL_W | Maskable interrupt level bits |
| boundary_i | input | 1 | Instruction-boundary strobe, evaluation point |
| ie_i | input | 1 | Global interrupt enable from the status register |
| im_i | input | LVL_W | Interrupt mask from the status register |
| exc_valid_o | output | 1 | Exception request pulse |
| exc_kind_o | output | 2 | 00 none, 01 NMI/reset, 10 interrupt |
| cause_ip_o | output | LVL_W | Hardware-interrupt pending field of the cause register |

## Verification
A pending flag that is wrong inside the block shows at the first boundary after the fault. It appears as a missing, extra or wrong-kind pulse on `exc_valid_o`/`exc_kind_o` in that same cycle. A wrong pending level or a lost end-of-interrupt marker shows one cycle after the boundary as a wrong `cause_ip_o`. A level that was wrongly dropped shows later, when the mask opens and no interrupt follows. The scenarios therefore put boundaries right after each kind of request, and they unmask held levels later on purpose, so that every kind of lost state reaches the ports.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

   typedef enum logic [1:0] {
      EXC_NONE   = 2'b00,
      EXC_NMIRST = 2'b01,
      EXC_INTR   = 2'b10
   } exc_kind_e;

   // sticky single-bit request sources, in priority order (index 0 first)
   localparam int unsigned NUM_HARD = 2;
   localparam int unsigned SRC_RST  = 0;
   localparam int unsigned SRC_NMI  = 1;

endpackage

// File: rtl/irq_sticky_flags.sv
module irq_sticky_flags #(
   parameter int unsigned N = 2
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [N-1:0] set_i,
   input  logic [N-1:0] clr_i,
   output logic [N-1:0] pend_o
);

   if (N < 1) begin : g_bad_n
      $error("irq_sticky_flags: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_flag
      logic pend_q;
      always_ff @(posedge clk) begin
         if (rst)
            pend_q <= 1'b0;
         else if (set_i[i])
            pend_q <= 1'b1;   // a new request wins over a same-cycle service
         else if (clr_i[i])
            pend_q <= 1'b0;
      end
      assign pend_o[i] = pend_q;
   end

endmodule

// File: rtl/irq_level_track.sv
module irq_level_track #(
   parameter int unsigned LVL_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             chg_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             take_lvl_i,
   input  logic             take_eoi_i,
   output logic [LVL_W-1:0] lvl_o,
   output logic             lvl_vld_o,
   output logic             eoi_o
);

   logic [LVL_W-1:0] lvl_q;
   logic             vld_q;
   logic             eoi_q;
   logic             chg_zero;

   assign chg_zero = chg_i && (lvl_i == '0);

   always_ff @(posedge clk) begin
      if (rst) begin
         lvl_q <= '0;
         vld_q <= 1'b0;
         eoi_q <= 1'b0;
      end else if (chg_i) begin
         // a fresh change replaces any level or marker still pending
         lvl_q <= lvl_i;
         vld_q <= !chg_zero;
         eoi_q <= chg_zero;
      end else begin
         if (take_lvl_i) begin
            vld_q <= 1'b0;
            lvl_q <= '0;
         end
         if (take_eoi_i)
            eoi_q <= 1'b0;
      end
   end

   assign lvl_o     = lvl_q;
   assign lvl_vld_o = vld_q;
   assign eoi_o     = eoi_q;

endmodule

// File: rtl/irq_select.sv
module irq_select
   import irq_arb_pkg::*;
#(
   parameter int unsigned LVL_W = 6
) (
   input  logic                boundary_i,
   input  logic [NUM_HARD-1:0] hard_pend_i,
   input  logic                eoi_i,
   input  logic                lvl_vld_i,
   input  logic [LVL_W-1:0]    lvl_i,
   input  logic                ie_i,
   input  logic [LVL_W-1:0]    im_i,
   output logic                exc_valid_o,
   output exc_kind_e           exc_kind_o,
   output logic [NUM_HARD-1:0] hard_clr_o,
   output logic                take_lvl_o,
   output logic                take_eoi_o,
   output logic                ip_we_o,
   output logic [LVL_W-1:0]    ip_val_o
);

   logic unmasked;
   logic hard_any;
   logic [NUM_HARD-1:0] hard_first;

   assign unmasked = ie_i && ((lvl_i & im_i) != '0);
   assign hard_any = |hard_pend_i;

   // lowest index has priority
   always_comb begin
      hard_first = '0;
      for (int i = NUM_HARD - 1; i >= 0; i--) begin
         if (hard_pend_i[i]) begin
            hard_first    = '0;
            hard_first[i] = 1'b1;
         end
      end
   end

   always_comb begin
      exc_valid_o = 1'b0;
      exc_kind_o  = EXC_NONE;
      hard_clr_o  = '0;
      take_lvl_o  = 1'b0;
      take_eoi_o  = 1'b0;
      ip_we_o     = 1'b0;
      ip_val_o    = '0;
      if (boundary_i) begin
         if (hard_any) begin
            hard_clr_o  = hard_first;
            exc_valid_o = 1'b1;
            exc_kind_o  = EXC_NMIRST;
         end else if (eoi_i) begin
            take_eoi_o = 1'b1;
            ip_we_o    = 1'b1;
         end else if (lvl_vld_i) begin
            ip_we_o  = 1'b1;
            ip_val_o = lvl_i;
            if (unmasked) begin
               take_lvl_o  = 1'b1;
               exc_valid_o = 1'b1;
               exc_kind_o  = EXC_INTR;
            end
         end
      end
   end

endmodule

// File: rtl/cpu_irq_arbiter.sv
module cpu_irq_arbiter
   import irq_arb_pkg::*;
#(
   parameter int unsigned LVL_W = 6
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             rst_req_i,
   input  logic             nmi_req_i,
   input  logic             lvl_chg_i,
   input  logic [LVL_W-1:0] lvl_i,
   input  logic             boundary_i,
   input  logic             ie_i,
   input  logic [LVL_W-1:0] im_i,
   output logic             exc_valid_o,
   output logic [1:0]       exc_kind_o,
   output logic [LVL_W-1:0] cause_ip_o
);

   if (LVL_W < 1 || LVL_W > 16) begin : g_bad_width
      $error("cpu_irq_arbiter: LVL_W must lie in 1..16");
   end

   logic [NUM_HARD-1:0] hard_set;
   logic [NUM_HARD-1:0] hard_clr;
   logic [NUM_HARD-1:0] hard_pend;
   logic                rst_pend;
   logic                nmi_pend;
   logic                eoi_pend;
   logic                lvl_vld;
   logic [LVL_W-1:0]    lvl_pend;
   logic                take_lvl;
   logic                take_eoi;
   logic                ip_we;
   logic [LVL_W-1:0]    ip_val;
   exc_kind_e           kind;
   logic [LVL_W-1:0]    cause_q;

   always_comb begin
      hard_set          = '0;
      hard_set[SRC_RST] = rst_req_i;
      hard_set[SRC_NMI] = nmi_req_i;
   end

   assign rst_pend = hard_pend[SRC_RST];
   assign nmi_pend = hard_pend[SRC_NMI];

   irq_sticky_flags #(.N(NUM_HARD)) u_flags (
      .clk    (clk),
      .rst    (rst),
      .set_i  (hard_set),
      .clr_i  (hard_clr),
      .pend_o (hard_pend)
   );

   irq_level_track #(.LVL_W(LVL_W)) u_level (
      .clk        (clk),
      .rst        (rst),
      .chg_i      (lvl_chg_i),
      .lvl_i      (lvl_i),
      .take_lvl_i (take_lvl),
      .take_eoi_i (take_eoi),
      .lvl_o      (lvl_pend),
      .lvl_vld_o  (lvl_vld),
      .eoi_o      (eoi_pend)
   );

   irq_select #(.LVL_W(LVL_W)) u_select (
      .boundary_i  (boundary_i),
      .hard_pend_i (hard_pend),
      .eoi_i       (eoi_pend),
      .lvl_vld_i   (lvl_vld),
      .lvl_i       (lvl_pend),
      .ie_i        (ie_i),
      .im_i        (im_i),
      .exc_valid_o (exc_valid_o),
      .exc_kind_o  (kind),
      .hard_clr_o  (hard_clr),
      .take_lvl_o  (take_lvl),
      .take_eoi_o  (take_eoi),
      .ip_we_o     (ip_we),
      .ip_val_o    (ip_val)
   );

   always_ff @(posedge clk) begin
      if (rst)
         cause_q <= '0;
      else if (ip_we)
         cause_q <= ip_val;
   end

   assign exc_kind_o = kind;
   assign cause_ip_o = cause_q;

endmodule

// File: rtl/irq_arb_chk.sv
module irq_arb_chk #(
   parameter int unsigned LVL_W = 6
) (
   input logic             clk,
   input logic             rst,
   input logic             boundary_i,
   input logic             lvl_chg_i,
   input logic             ie_i,
   input logic [LVL_W-1:0] im_i,
   input logic             exc_valid_o,
   input logic [1:0]       exc_kind_o,
   input logic [LVL_W-1:0] cause_ip_o,
   input logic             rst_pend,
   input logic             nmi_pend,
   input logic             eoi_pend,
   input logic             lvl_vld,
   input logic [LVL_W-1:0] lvl_pend
);

   assert_rst_first_R4: assert property (@(posedge clk) disable iff (rst)
      boundary_i && rst_pend |-> exc_valid_o && exc_kind_o == 2'b01);

   assert_nmi_over_level_R4: assert property (@(posedge clk) disable iff (rst)
      boundary_i && nmi_pend |-> exc_valid_o && exc_kind_o == 2'b01);

   assert_pulse_at_boundary_R5: assert property (@(posedge clk) disable iff (rst)
      exc_valid_o |-> boundary_i);

   assert_kind_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !exc_valid_o |-> exc_kind_o == 2'b00);

   assert_cause_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !boundary_i |=> $stable(cause_ip_o));

   assert_intr_allowed_R7: assert property (@(posedge clk) disable iff (rst)
      exc_valid_o && exc_kind_o == 2'b10 |-> lvl_vld && ie_i && ((im_i & lvl_pend) != '0));

   assert_masked_kept_R8: assert property (@(posedge clk) disable iff (rst)
      boundary_i && !rst_pend && !nmi_pend && !eoi_pend && lvl_vld && !lvl_chg_i
      && !(ie_i && ((im_i & lvl_pend) != '0)) |=> lvl_vld);

   assert_eoi_clears_R9: assert property (@(posedge clk) disable iff (rst)
      boundary_i && !rst_pend && !nmi_pend && eoi_pend |=> cause_ip_o == '0);

endmodule

bind cpu_irq_arbiter irq_arb_chk #(.LVL_W(LVL_W)) u_irq_arb_chk (
   .clk         (clk),
   .rst         (rst),
   .boundary_i  (boundary_i),
   .lvl_chg_i   (lvl_chg_i),
   .ie_i        (ie_i),
   .im_i        (im_i),
   .exc_valid_o (exc_valid_o),
   .exc_kind_o  (exc_kind_o),
   .cause_ip_o  (cause_ip_o),
   .rst_pend    (rst_pend),
   .nmi_pend    (nmi_pend),
   .eoi_pend    (eoi_pend),
   .lvl_vld     (lvl_vld),
   .lvl_pend    (lvl_pend)
);

// File: tb/cpu_irq_arbiter_tb.sv
module cpu_irq_arbiter_tb;

   localparam int W = 6;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         rst_req_i = 1'b0;
   logic         nmi_req_i = 1'b0;
   logic         lvl_chg_i = 1'b0;
   logic [W-1:0] lvl_i = '0;
   logic         boundary_i = 1'b0;
   logic         ie_i = 1'b0;
   logic [W-1:0] im_i = '0;
   logic         exc_valid_o;
   logic [1:0]   exc_kind_o;
   logic [W-1:0] cause_ip_o;

   int checks = 0;
   int failures = 0;
   bit mon_on = 1'b0;
   bit done = 1'b0;

   typedef struct {
      logic [1:0]   kind;
      logic [W-1:0] cause;
      string        tag;
   } exp_t;

   exp_t sb_q[$];

   always #2 clk = ~clk;   // 250 MHz

   cpu_irq_arbiter #(.LVL_W(W)) u_dut (
      .clk(clk), .rst(rst), .rst_req_i(rst_req_i), .nmi_req_i(nmi_req_i),
      .lvl_chg_i(lvl_chg_i), .lvl_i(lvl_i), .boundary_i(boundary_i),
      .ie_i(ie_i), .im_i(im_i), .exc_valid_o(exc_valid_o),
      .exc_kind_o(exc_kind_o), .cause_ip_o(cause_ip_o)
   );

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   // driver: one boundary cycle followed by one idle cycle
   task automatic boundary(input logic [1:0] kind, input logic [W-1:0] cause,
                           input string tag);
      exp_t e;
      e.kind = kind; e.cause = cause; e.tag = tag;
      sb_q.push_back(e);
      @(posedge clk); #1 boundary_i = 1'b1;
      @(posedge clk); #1 boundary_i = 1'b0;
      @(posedge clk); #1;
   endtask

   task automatic pulse(input bit r, input bit n);
      @(posedge clk); #1 rst_req_i = r; nmi_req_i = n;
      @(posedge clk); #1 rst_req_i = 1'b0; nmi_req_i = 1'b0;
   endtask

   task automatic set_level(input logic [W-1:0] v);
      @(posedge clk); #1 lvl_chg_i = 1'b1; lvl_i = v;
      @(posedge clk); #1 lvl_chg_i = 1'b0; lvl_i = '0;
   endtask

   // monitor: pops expectations as boundaries occur
   initial begin
      bit   cause_due = 1'b0;
      exp_t cur;
      forever begin
         @(negedge clk);
         if (mon_on) begin
            if (boundary_i) begin
               if (sb_q.size() == 0) begin
                  check(1'b0, "R5", "unexpected boundary", 0, 1);
               end else begin
                  cur = sb_q.pop_front();
                  check(exc_valid_o == (cur.kind != 2'b00), cur.tag, "exc_valid",
                        int'(exc_valid_o), int'(cur.kind != 2'b00));
                  check(exc_kind_o == cur.kind, cur.tag, "exc_kind",
                        int'(exc_kind_o), int'(cur.kind));
                  cause_due = 1'b1;
               end
            end else begin
               check(exc_valid_o == 1'b0, "R5", "pulse outside boundary",
                     int'(exc_valid_o), 0);
               if (cause_due) begin
                  check(cause_ip_o == cur.cause, cur.tag, "cause_ip",
                        int'(cause_ip_o), int'(cur.cause));
                  cause_due = 1'b0;
               end
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst = 1'b0;
      @(negedge clk);
      // R1: reset state
      check(cause_ip_o == '0, "R1", "cause after reset", int'(cause_ip_o), 0);
      check(exc_valid_o == 1'b0, "R1", "valid after reset", int'(exc_valid_o), 0);
      mon_on = 1'b1;
      boundary(2'b00, 6'h00, "R1");

      // R2: reset request
      pulse(1'b1, 1'b0);
      boundary(2'b01, 6'h00, "R2");
      boundary(2'b00, 6'h00, "R2");

      // R3: NMI request
      pulse(1'b0, 1'b1);
      boundary(2'b01, 6'h00, "R3");
      boundary(2'b00, 6'h00, "R3");

      // R4: reset and NMI together
      pulse(1'b1, 1'b1);
      boundary(2'b01, 6'h00, "R4");
      boundary(2'b01, 6'h00, "R4");
      boundary(2'b00, 6'h00, "R4");

      // R6, R7: enabled, unmasked level
      @(posedge clk); #1 ie_i = 1'b1; im_i = 6'h3F;
      set_level(6'h05);
      boundary(2'b10, 6'h05, "R7");
      boundary(2'b00, 6'h05, "R6");

      // R9: end-of-interrupt marker
      set_level(6'h00);
      boundary(2'b00, 6'h00, "R9");
      boundary(2'b00, 6'h00, "R9");

      // R8: masked, then disabled, then delivered
      @(posedge clk); #1 im_i = 6'h02;
      set_level(6'h05);
      boundary(2'b00, 6'h05, "R8");
      boundary(2'b00, 6'h05, "R8");
      @(posedge clk); #1 ie_i = 1'b0; im_i = 6'h3F;
      boundary(2'b00, 6'h05, "R8");
      @(posedge clk); #1 ie_i = 1'b1;
      boundary(2'b10, 6'h05, "R8");
      boundary(2'b00, 6'h05, "R8");

      // R10: later change replaces earlier level
      @(posedge clk); #1 im_i = 6'h30;
      set_level(6'h03);
      set_level(6'h30);
      boundary(2'b10, 6'h30, "R10");

      // R11: NMI takes the boundary, cause untouched
      @(posedge clk); #1 im_i = 6'h3F;
      pulse(1'b0, 1'b1);
      set_level(6'h0C);
      boundary(2'b01, 6'h30, "R11");
      boundary(2'b10, 6'h0C, "R11");

      // R5: request held over idle cycles
      pulse(1'b1, 1'b0);
      repeat (6) @(posedge clk);
      #1;
      boundary(2'b01, 6'h0C, "R5");

      // R9/R10: marker replaces a masked level
      @(posedge clk); #1 im_i = 6'h00;
      set_level(6'h07);
      boundary(2'b00, 6'h07, "R10");
      set_level(6'h00);
      boundary(2'b00, 6'h00, "R9");
      @(posedge clk); #1 im_i = 6'h3F;
      boundary(2'b00, 6'h00, "R9");

      // R1: block reset discards pending requests
      pulse(1'b0, 1'b1);
      set_level(6'h21);
      @(posedge clk); #1 rst = 1'b1;
      @(posedge clk); #1 rst = 1'b0;
      @(negedge clk);
      check(cause_ip_o == '0, "R1", "cause after block reset", int'(cause_ip_o), 0);
      boundary(2'b00, 6'h00, "R1");
      boundary(2'b00, 6'h00, "R1");

      repeat (2) @(posedge clk);
      check(sb_q.size() == 0, "R5", "unconsumed expectations", sb_q.size(), 0);
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule